// File: doc/BRIEF.md
# Multi-Lane Pixel Word Serializer

This block takes one parallel pixel word per pixel period and sends it over one, two or three serial data lanes. A pixel word is 24 colour bits plus vertical sync, horizontal sync and data enable. Everything runs on a high-speed bit clock that is already locked to the pixel rate. The pixel clock arrives as a level that the block samples on the bit clock. On the selected edge of that level, the block builds a 30-bit frame: the colour and control bits, an odd-parity bit and two reserved zero bits. It holds that frame until the current frame ends. A shift register then moves the frame out, most significant bit first, spread round-robin across the active lanes. A separate forwarded-clock lane is high for the first half of each frame's bit slots and low for the second half, so a receiver can find the frame boundary. The bit clock must run at 30, 15 or 10 times the pixel rate for one, two or three lanes.

A small state machine controls the shifting. Reset enters `ST_WAIT`: all lanes and the forwarded clock are low, and no frame has been captured yet. The transition `T_START` moves to `ST_SHIFT` on the first bit-clock edge at which a captured frame is held. In `ST_SHIFT`, `T_SHIFT` advances the slot counter and shifts the register by the active lane count. On the final slot, `T_RELOAD` loads the latest captured frame and the link-select value, and the counter starts again at slot zero. Reset from any state returns to `ST_WAIT`.

Top module: `pxs_serializer`

## Requirements
- R1: The frame layout is: bits 29:22 red[7:0], bits 21:14 green[7:0], bits 13:6 blue[7:0], bit 5 vertical sync, bit 4 horizontal sync, bit 3 data enable, bit 2 parity, and bits 1:0 zero.
- R2: The parity bit makes frame bits 29:2 hold an odd number of ones.
- R3: `link_sel` 2'b00 selects 1 lane (30 slots per frame), 2'b01 selects 2 lanes (15 slots) and 2'b10 selects 3 lanes (10 slots). In slot s, lane k carries frame bit 29-(s*N+k), where N is the active lane count.
- R4: `link_sel` 2'b11 behaves exactly like single-lane mode.
- R5: Lanes at or above the active count are low. During reset, and until the first frame is loaded, all lanes and `fwd_clk_o` are low.
- R6: With `bus_swap` low, `pix_data[26:19]` is red[7:0], `[18:11]` is green[7:0], `[10:3]` is blue[7:0], and `[2:0]` is {vsync, hsync, de}. With `bus_swap` high, `pix_data[26:3]` is read bit-reversed: `pix_data[26]` is blue[0], `pix_data[19]` is blue[7], and `pix_data[10:3]` is red[0:7]. The control bits are unchanged.
- R7: With `pix_pol` low, a word is captured on a rising `pix_clk`. With `pix_pol` high, a word is captured on a falling `pix_clk`. The opposite edge captures nothing. The edge is seen at the first bit-clock edge after `pix_clk` changes. The first frame's slot 0 appears after the next bit-clock edge.
- R8: `fwd_clk_o` is high in slot s of a frame of S slots when 2*s < S, and low otherwise.
- R9: A newly captured word and a new `link_sel` value take effect only at a frame boundary. If no new word has been captured, the last word is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | High-speed bit clock, locked to the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_clk | input | 1 | Pixel clock level, sampled on bit_clk |
| pix_pol | input | 1 | Capture edge select: 0 rising, 1 falling |
| bus_swap | input | 1 | Reverses the read order of the colour bus |
| link_sel | input | 2 | Active lane count select |
| pix_data | input | 27 | Parallel pixel word |
| lane_o | output | 3 | Serial data lanes |
| fwd_clk_o | output | 1 | Forwarded frame-rate clock pattern |

## Verification
The bench sends all-ones, all-zeros and single-bit words in every lane mode and in both bus orders. A design with inverted parity fails the all-zeros word. A design that misplaces a lane, reverses the wrong field or leaves an unused lane active produces a decoded frame that differs from the model.

A rising `pix_clk` with `pix_pol` high must leave the outputs silent. A design that ignores polarity would start sending early. In another test, a new word and a new `link_sel` arrive in the middle of a frame. A design that reloads early would corrupt the frame in flight. A design that never latches the new lane count would decode the following frame with the wrong slot count and the wrong forwarded-clock pattern.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
package pxs_pkg;

    typedef enum logic [1:0] {
        LANES_1 = 2'd1,
        LANES_2 = 2'd2,
        LANES_3 = 2'd3
    } lane_cnt_e;

    typedef enum logic {
        ST_WAIT  = 1'b0,
        ST_SHIFT = 1'b1
    } shift_state_e;

    function automatic lane_cnt_e decode_sel(input logic [1:0] sel);
        case (sel)
            2'b01:   return LANES_2;
            2'b10:   return LANES_3;
            default: return LANES_1;
        endcase
    endfunction

    function automatic int slots_for(input int frame_w, input lane_cnt_e n);
        case (n)
            LANES_2: return frame_w / 2;
            LANES_3: return frame_w / 3;
            default: return frame_w;
        endcase
    endfunction

endpackage

// File: rtl/pxs_capture.sv
`timescale 1ns/1ps
module pxs_capture
    import pxs_pkg::*;
#(
    parameter int COLOR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_clk,
    input  logic                 pix_pol,
    input  logic                 swap,
    input  logic [3*COLOR_W+2:0] pix_bus,
    output logic [3*COLOR_W+5:0] frame_o,
    output logic                 word_vld_o
);
    localparam int CW      = 3 * COLOR_W;
    localparam int DATA_W  = CW + 3;
    localparam int FRAME_W = DATA_W + 3;

    logic              pclk_q;
    logic              cap;
    logic [CW-1:0]     color_n;
    logic [DATA_W-1:0] data_w;
    logic              parity;
    logic [FRAME_W-1:0] frame_d;

    // Edge detect on the sampled pixel clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) pclk_q <= 1'b0;
        else        pclk_q <= pix_clk;
    end

    assign cap = pix_pol ? (pclk_q & ~pix_clk) : (~pclk_q & pix_clk);

    // Colour field: straight or fully bit-reversed (red/blue exchange + per-colour reversal).
    for (genvar j = 0; j < CW; j++) begin : g_color
        assign color_n[j] = swap ? pix_bus[3 + (CW - 1 - j)] : pix_bus[3 + j];
    end

    assign data_w  = {color_n, pix_bus[2:0]};
    assign parity  = ~^data_w;
    assign frame_d = {data_w, parity, 2'b00};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o    <= '0;
            word_vld_o <= 1'b0;
        end else if (cap) begin
            frame_o    <= frame_d;
            word_vld_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pxs_shifter.sv
`timescale 1ns/1ps
module pxs_shifter
    import pxs_pkg::*;
#(
    parameter int COLOR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_vld,
    input  logic [3*COLOR_W+5:0] word,
    input  logic [1:0]           link_sel,
    output shift_state_e         state_o,
    output lane_cnt_e            mode_o,
    output logic [$clog2(3*COLOR_W+7)-1:0] slot_o,
    output logic [3*COLOR_W+5:0] sr_o
);
    localparam int FRAME_W = 3 * COLOR_W + 6;
    localparam int SLOT_W  = $clog2(FRAME_W + 1);

    shift_state_e       state_q, state_d;
    lane_cnt_e          mode_q, mode_d;
    logic [SLOT_W-1:0]  slot_q, slot_d, last_slot;
    logic [FRAME_W-1:0] sr_q, sr_d, sr_shift;

    always_comb last_slot = SLOT_W'(slots_for(FRAME_W, mode_q) - 1);

    always_comb begin
        case (mode_q)
            LANES_2: sr_shift = sr_q << 2;
            LANES_3: sr_shift = sr_q << 3;
            default: sr_shift = sr_q << 1;
        endcase
    end

    // Next-state and datapath decisions.
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        slot_d  = slot_q;
        sr_d    = sr_q;
        unique case (state_q)
            ST_WAIT: begin
                if (word_vld) begin          // T_START
                    state_d = ST_SHIFT;
                    mode_d  = decode_sel(link_sel);
                    slot_d  = '0;
                    sr_d    = word;
                end
            end
            ST_SHIFT: begin
                if (slot_q == last_slot) begin   // T_RELOAD
                    mode_d = decode_sel(link_sel);
                    slot_d = '0;
                    sr_d   = word;
                end else begin                   // T_SHIFT
                    slot_d = slot_q + 1'b1;
                    sr_d   = sr_shift;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            mode_q  <= LANES_1;
            slot_q  <= '0;
            sr_q    <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            slot_q  <= slot_d;
            sr_q    <= sr_d;
        end
    end

    assign state_o = state_q;
    assign mode_o  = mode_q;
    assign slot_o  = slot_q;
    assign sr_o    = sr_q;
endmodule

// File: rtl/pxs_lane_out.sv
`timescale 1ns/1ps
module pxs_lane_out
    import pxs_pkg::*;
#(
    parameter int COLOR_W   = 8,
    parameter int MAX_LANES = 3
) (
    input  shift_state_e         state,
    input  lane_cnt_e            mode,
    input  logic [$clog2(3*COLOR_W+7)-1:0] slot,
    input  logic [3*COLOR_W+5:0] sr,
    output logic [MAX_LANES-1:0] lane_o,
    output logic                 fclk_o
);
    localparam int FRAME_W = 3 * COLOR_W + 6;

    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
        assign lane_o[k] = (state == ST_SHIFT) && (k < int'(mode)) && sr[FRAME_W - 1 - k];
    end

    assign fclk_o = (state == ST_SHIFT) && ((int'(slot) * 2) < slots_for(FRAME_W, mode));
endmodule

// File: rtl/pxs_serializer.sv
`timescale 1ns/1ps
module pxs_serializer
    import pxs_pkg::*;
#(
    parameter int COLOR_W = 8
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 pix_clk,
    input  logic                 pix_pol,
    input  logic                 bus_swap,
    input  logic [1:0]           link_sel,
    input  logic [3*COLOR_W+2:0] pix_data,
    output logic [2:0]           lane_o,
    output logic                 fwd_clk_o
);
    localparam int FRAME_W = 3 * COLOR_W + 6;
    localparam int SLOT_W  = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame_w;
    logic               word_vld_w;
    shift_state_e       state_w;
    lane_cnt_e          mode_w;
    logic [SLOT_W-1:0]  slot_w;
    logic [FRAME_W-1:0] sr_w;

    pxs_capture #(.COLOR_W(COLOR_W)) u_capture (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .pix_clk    (pix_clk),
        .pix_pol    (pix_pol),
        .swap       (bus_swap),
        .pix_bus    (pix_data),
        .frame_o    (frame_w),
        .word_vld_o (word_vld_w)
    );

    pxs_shifter #(.COLOR_W(COLOR_W)) u_shifter (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .word_vld (word_vld_w),
        .word     (frame_w),
        .link_sel (link_sel),
        .state_o  (state_w),
        .mode_o   (mode_w),
        .slot_o   (slot_w),
        .sr_o     (sr_w)
    );

    pxs_lane_out #(.COLOR_W(COLOR_W), .MAX_LANES(3)) u_lane_out (
        .state  (state_w),
        .mode   (mode_w),
        .slot   (slot_w),
        .sr     (sr_w),
        .lane_o (lane_o),
        .fclk_o (fwd_clk_o)
    );
endmodule

// File: rtl/pxs_serializer_chk.sv
`timescale 1ns/1ps
module pxs_serializer_chk
    import pxs_pkg::*;
#(
    parameter int COLOR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input shift_state_e         state,
    input lane_cnt_e            mode,
    input logic [$clog2(3*COLOR_W+7)-1:0] slot,
    input logic [3*COLOR_W+5:0] frame,
    input logic                 frame_vld,
    input logic [2:0]           lane,
    input logic                 fclk
);
    localparam int FRAME_W = 3 * COLOR_W + 6;

    int last_slot;
    always_comb last_slot = slots_for(FRAME_W, mode) - 1;

    p_one_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LANES_1) |-> (lane[2:1] == 2'b00));

    p_two_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LANES_2) |-> !lane[2]);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (lane == 3'b000 && !fclk));

    p_fclk_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && slot == '0) |-> fclk);

    p_fclk_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && int'(slot) == last_slot) |-> !fclk);

    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (int'(slot) <= last_slot));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && int'(slot) != last_slot) |=> $stable(mode));

    p_parity_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> ($countones(frame[FRAME_W-1:2]) % 2 == 1));

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> (frame[1:0] == 2'b00));
endmodule

bind pxs_serializer pxs_serializer_chk #(.COLOR_W(COLOR_W)) u_chk (
    .clk       (bit_clk),
    .rst_n     (rst_n),
    .state     (state_w),
    .mode      (mode_w),
    .slot      (slot_w),
    .frame     (frame_w),
    .frame_vld (word_vld_w),
    .lane      (lane_o),
    .fclk      (fwd_clk_o)
);

// File: tb/pxs_serializer_tb.sv
`timescale 1ns/1ps
module pxs_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_clk = 1'b0;
    logic        pix_pol = 1'b0;
    logic        bus_swap = 1'b0;
    logic [1:0]  link_sel = 2'b00;
    logic [26:0] pix_data = '0;
    logic [2:0]  lane;
    logic        fclk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pxs_serializer #(.COLOR_W(8)) u_dut (
        .bit_clk   (clk),
        .rst_n     (rst_n),
        .pix_clk   (pix_clk),
        .pix_pol   (pix_pol),
        .bus_swap  (bus_swap),
        .link_sel  (link_sel),
        .pix_data  (pix_data),
        .lane_o    (lane),
        .fwd_clk_o (fclk)
    );

    // {link_sel, swap, bus, expected lane count}
    localparam logic [31:0] VEC [8] = '{
        {2'b00, 1'b0, 27'h0000001, 2'd1},
        {2'b00, 1'b0, 27'h0000000, 2'd1},
        {2'b01, 1'b0, 27'h2D3C1E7, 2'd2},
        {2'b10, 1'b0, 27'h7FFFFFF, 2'd3},
        {2'b11, 1'b0, 27'h1234567, 2'd1},
        {2'b00, 1'b1, 27'h4000000, 2'd1},
        {2'b10, 1'b1, 27'h0ABCDEF, 2'd3},
        {2'b01, 1'b1, 27'h6000005, 2'd2}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model of the frame per R1, R2, R6.
    function automatic logic [29:0] exp_frame(input logic [26:0] bus, input logic swp);
        logic [7:0] r, g, b;
        logic       par;
        for (int i = 0; i < 8; i++) begin
            if (swp) begin
                b[i] = bus[26 - i];
                g[i] = bus[18 - i];
                r[i] = bus[10 - i];
            end else begin
                r[i] = bus[19 + i];
                g[i] = bus[11 + i];
                b[i] = bus[3 + i];
            end
        end
        par = ($countones({r, g, b, bus[2:0]}) % 2 == 0);
        return {r, g, b, bus[2:0], par, 2'b00};
    endfunction

    task automatic do_reset(input logic pol, input logic pclk_lvl);
        @(negedge clk);
        rst_n   = 1'b0;
        pix_pol = pol;
        pix_clk = pclk_lvl;
        repeat (3) @(negedge clk);
        check(lane === 3'b000 && fclk === 1'b0, "R5 reset state", {28'd0, fclk, lane}, 32'd0);
        rst_n = 1'b1;
    endtask

    // Presents a word with the active pixel edge; returns at the negedge where slot 0 is visible.
    task automatic start_word(input logic [26:0] bus, input logic swp, input logic [1:0] ls);
        @(negedge clk);
        pix_data = bus;
        bus_swap = swp;
        link_sel = ls;
        pix_clk  = pix_pol ? 1'b0 : 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_frame(input int n, input logic [29:0] exp, input string req,
                              input int inj_at, input logic [1:0] inj_ls, input logic [26:0] inj_bus,
                              output logic [29:0] got);
        int  s_cnt;
        bit  unused_ok;
        bit  fclk_ok;
        got       = '0;
        s_cnt     = 30 / n;
        unused_ok = 1'b1;
        fclk_ok   = 1'b1;
        for (int s = 0; s < s_cnt; s++) begin
            for (int k = 0; k < 3; k++) begin
                if (k < n) got[29 - (s * n + k)] = lane[k];
                else if (lane[k] !== 1'b0) unused_ok = 1'b0;
            end
            if (fclk !== ((2 * s) < s_cnt)) fclk_ok = 1'b0;
            if (s == inj_at) begin
                link_sel = inj_ls;
                pix_data = inj_bus;
                pix_clk  = 1'b1;
            end
            @(negedge clk);
        end
        check(got === exp, req, {2'b00, got}, {2'b00, exp});
        check(unused_ok, "R5 unused lanes low", {31'd0, unused_ok}, 32'd1);
        check(fclk_ok, "R8 forwarded clock pattern", {31'd0, fclk_ok}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [29:0] got;
        logic [29:0] exp;
        logic [26:0] word_a;
        logic [26:0] word_b;

        // Table of vectors: R1, R2, R3, R4, R6 in every lane mode and bus order.
        for (int v = 0; v < 8; v++) begin
            logic [1:0]  ls;
            logic        swp;
            logic [26:0] bus;
            int          n;
            string       tag;
            ls  = VEC[v][31:30];
            swp = VEC[v][29];
            bus = VEC[v][28:2];
            n   = int'(VEC[v][1:0]);
            tag = (ls == 2'b11) ? "R4 invalid select single lane" :
                  swp ? "R6 R1 swapped bus" : "R1 R3 lane layout";
            do_reset(1'b0, 1'b0);
            start_word(bus, swp, ls);
            exp = exp_frame(bus, swp);
            read_frame(n, exp, tag, -1, 2'b00, '0, got);
            check($countones(got[29:2]) % 2 == 1, "R2 odd parity", {2'b00, got}, {2'b00, exp});
            // R9: no new word captured, same frame repeats.
            read_frame(n, exp, "R9 repeat last word", -1, 2'b00, '0, got);
        end

        // R5: outputs stay low after reset while no edge occurs.
        do_reset(1'b0, 1'b0);
        repeat (40) @(negedge clk);
        check(lane === 3'b000 && fclk === 1'b0, "R5 idle before first word", {28'd0, fclk, lane}, 32'd0);

        // R7: falling-edge capture; rising edge ignored.
        word_a = 27'h1555555;
        word_b = 27'h0F0F0F3;
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        pix_data = word_a;
        link_sel = 2'b00;
        bus_swap = 1'b0;
        pix_clk  = 1'b1;
        repeat (40) @(negedge clk);
        check(lane === 3'b000 && fclk === 1'b0, "R7 opposite edge ignored", {28'd0, fclk, lane}, 32'd0);
        start_word(word_b, 1'b0, 2'b10);
        read_frame(3, exp_frame(word_b, 1'b0), "R7 falling edge capture", -1, 2'b00, '0, got);

        // R9: mid-frame word and lane change wait for the frame boundary.
        do_reset(1'b0, 1'b0);
        start_word(word_a, 1'b0, 2'b00);
        pix_clk = 1'b0;
        read_frame(1, exp_frame(word_a, 1'b0), "R9 frame in flight kept", 5, 2'b01, word_b, got);
        read_frame(2, exp_frame(word_b, 1'b0), "R9 R3 new word and mode at boundary", -1, 2'b00, '0, got);

        // R4: change from three lanes to the invalid code at a boundary.
        do_reset(1'b0, 1'b0);
        start_word(word_b, 1'b1, 2'b10);
        pix_clk = 1'b0;
        read_frame(3, exp_frame(word_b, 1'b1), "R6 R3 three-lane swapped", 2, 2'b11, word_a, got);
        read_frame(1, exp_frame(word_a, 1'b1), "R4 invalid select after boundary", -1, 2'b00, '0, got);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule